// File: doc/BRIEF.md
# Two-Channel Transmit Priority Arbiter

This block decides which of two transmit request channels owns a shared transmit path toward the ring engine. Channel 0 is the urgent channel and channel 1 is the background channel. When both ask at once, channel 0 wins. A background channel that already holds the path can be displaced in one of two ways. With preemption armed, the switch happens as soon as channel 1 has no committed frame in flight. Without preemption, channel 0 waits until channel 1 finishes.

On a preemption the arbiter strobes a purge so that the background FIFO drops its uncommitted bytes. It then blocks channel 1 from loading more data. When channel 0 later gives up the path, the arbiter raises a one-cycle refetch request so the discarded data is fetched again.

A per-channel hold bit keeps the current owner in place for the rest of a service opportunity. A staging gate tells each channel whether it may load FIFO data before a token is captured. Channel 0 may always stage. Channel 1 may stage only when its prestage option is set or a service opportunity exists.

Top module: `tx_prio_arb`

## Requirements
- R1: During and right after reset, `grant_o` is 2'b00 and `purge1_o` and `refetch1_o` are low.
- R2: `grant_o` is one-hot or zero. Bit 0 means channel 0 owns the path and bit 1 means channel 1 owns it. From the idle state, the cycle after a request it is 2'b01 if `req_act_i[0]` is set, else 2'b10 if `req_act_i[1]` is set, else 2'b00.
- R3: While channel 0 owns the path and `req_act_i[0]` stays high, it keeps the grant whatever channel 1 does.
- R4: With `preempt_en_i` low, a channel 1 owner that is still active keeps the grant even when channel 0 becomes active.
- R5: Suppose channel 1 owns the path and is active, channel 0 is active, `preempt_en_i` is high, `commit1_i` is low, and no hold applies. Then on the next cycle `grant_o` becomes 2'b01 and `purge1_o` is high for exactly that cycle.
- R6: While `commit1_i` is high, channel 1 is not purged and keeps the grant. The preemption takes effect the cycle after `commit1_i` falls.
- R7: With `hold_i[1]` and `svc_opp_i` both high, a channel 1 owner keeps the grant, even against a preempting channel 0 or after its own request drops.
- R8: With `hold_i[0]` and `svc_opp_i` both high, a channel 0 owner keeps the grant after `req_act_i[0]` drops, even when channel 1 is active.
- R9: `refetch1_o` is high for exactly one cycle. That cycle is the first one after channel 0 loses a grant it gained by preemption. Otherwise it is never high.
- R10: `stage_ok_o[0]` equals `req_act_i[0]` in the same cycle, because prestaging is forced for channel 0.
- R11: `stage_ok_o[1]` equals `req_act_i[1] & (stage1_en_i | svc_opp_i)`. It is forced low from a preemption until the matching refetch.
- R12: When channel 0 releases without a hold, the grant passes to an active channel 1 on the next cycle, or else to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_act_i | input | 2 | Per-channel active request |
| hold_i | input | 2 | Per-channel hold for the current service opportunity |
| preempt_en_i | input | 1 | Allow channel 0 to preempt channel 1 |
| stage1_en_i | input | 1 | Prestage option for channel 1 |
| svc_opp_i | input | 1 | A service opportunity is present |
| commit1_i | input | 1 | Channel 1 has a frame committed to transmission |
| grant_o | output | 2 | One-hot path owner |
| purge1_o | output | 1 | One-cycle purge of channel 1 uncommitted FIFO data |
| refetch1_o | output | 1 | One-cycle request to refetch purged channel 1 data |
| stage_ok_o | output | 2 | Per-channel permission to load FIFO data |

## Verification
A corrupted grant state shows on `grant_o` in the first cycle after the bad transition, because the grant register drives that port directly. A lost or stuck preemption flag appears in two ways. First, `stage_ok_o[1]` stays blocked or opens too early in the same cycle. Second, `refetch1_o` is missing or extra on the cycle after channel 0 releases. The sweeps therefore check all 32 combinations of the inputs that decide a channel 1 displacement. For each combination they check the grant, the purge and the refetch on their exact cycles.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic [NUM_CH-1:0] {
    GS_IDLE = 2'b00,
    GS_CH0  = 2'b01,
    GS_CH1  = 2'b10
  } gnt_state_e;
endpackage

// File: rtl/tx_arb_grant_fsm.sv
module tx_arb_grant_fsm
  import tx_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] act,
  input  logic [NUM_CH-1:0] hold,
  input  logic              preempt_en,
  input  logic              svc_opp,
  input  logic              commit1,
  output gnt_state_e        state_q,
  output logic              preempt_evt,
  output logic              rel0_evt
);
  gnt_state_e state_d;
  logic       held0;
  logic       held1;

  assign held0 = hold[0] & svc_opp;
  assign held1 = hold[1] & svc_opp;

  always_comb begin
    state_d     = state_q;
    preempt_evt = 1'b0;
    case (state_q)
      GS_IDLE: begin
        if (act[0])      state_d = GS_CH0;
        else if (act[1]) state_d = GS_CH1;
      end
      GS_CH0: begin
        if (!(act[0] || held0)) begin
          if (act[1]) state_d = GS_CH1;
          else        state_d = GS_IDLE;
        end
      end
      GS_CH1: begin
        if (!held1) begin
          if (!act[1]) begin
            state_d = act[0] ? GS_CH0 : GS_IDLE;
          end else if (act[0] && preempt_en && !commit1) begin
            state_d     = GS_CH0;
            preempt_evt = 1'b1;
          end
        end
      end
      default: state_d = GS_IDLE;
    endcase
  end

  assign rel0_evt = (state_q == GS_CH0) && (state_d != GS_CH0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tx_arb_preempt_ctl.sv
module tx_arb_preempt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic preempt_evt,
  input  logic rel0_evt,
  output logic purge_q,
  output logic refetch_q,
  output logic pend_q
);
  logic purge_d;
  logic refetch_d;
  logic pend_d;
  logic pend_en;

  always_comb begin
    purge_d   = preempt_evt;
    refetch_d = pend_q & rel0_evt;
    pend_en   = preempt_evt | (pend_q & rel0_evt);
    pend_d    = preempt_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      purge_q   <= 1'b0;
      refetch_q <= 1'b0;
    end else begin
      purge_q   <= purge_d;
      refetch_q <= refetch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/tx_arb_stage_gate.sv
module tx_arb_stage_gate
  import tx_arb_pkg::*;
#(
  parameter logic [NUM_CH-1:0] FORCE_MASK = 2'b01
) (
  input  logic [NUM_CH-1:0] act,
  input  logic [NUM_CH-1:0] stage_en,
  input  logic [NUM_CH-1:0] block,
  input  logic              svc_opp,
  output logic [NUM_CH-1:0] stage_ok
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (FORCE_MASK[i]) begin : g_forced
      assign stage_ok[i] = act[i] & ~block[i];
    end else begin : g_opt
      assign stage_ok[i] = act[i] & (stage_en[i] | svc_opp) & ~block[i];
    end
  end
endmodule

// File: rtl/tx_prio_arb.sv
module tx_prio_arb
  import tx_arb_pkg::*;
#(
  parameter logic [1:0] STAGE_FORCE_MASK = 2'b01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_act_i,
  input  logic [1:0] hold_i,
  input  logic       preempt_en_i,
  input  logic       stage1_en_i,
  input  logic       svc_opp_i,
  input  logic       commit1_i,
  output logic [1:0] grant_o,
  output logic       purge1_o,
  output logic       refetch1_o,
  output logic [1:0] stage_ok_o
);
  gnt_state_e state;
  logic       preempt_evt;
  logic       rel0_evt;
  logic       pend;

  tx_arb_grant_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (req_act_i),
    .hold        (hold_i),
    .preempt_en  (preempt_en_i),
    .svc_opp     (svc_opp_i),
    .commit1     (commit1_i),
    .state_q     (state),
    .preempt_evt (preempt_evt),
    .rel0_evt    (rel0_evt)
  );

  tx_arb_preempt_ctl u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .preempt_evt (preempt_evt),
    .rel0_evt    (rel0_evt),
    .purge_q     (purge1_o),
    .refetch_q   (refetch1_o),
    .pend_q      (pend)
  );

  tx_arb_stage_gate #(.FORCE_MASK(STAGE_FORCE_MASK)) u_stage (
    .act      (req_act_i),
    .stage_en ({stage1_en_i, 1'b0}),
    .block    ({pend, 1'b0}),
    .svc_opp  (svc_opp_i),
    .stage_ok (stage_ok_o)
  );

  assign grant_o = state;
endmodule

// File: rtl/tx_prio_arb_chk.sv
module tx_prio_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_act_i,
  input logic       commit1_i,
  input logic [1:0] grant_o,
  input logic       purge1_o,
  input logic       refetch1_o,
  input logic [1:0] stage_ok_o
);
  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r3_ch0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o[0] && req_act_i[0]) |=> grant_o[0]);
  a_r5_purge_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    purge1_o |-> (grant_o[0] && $past(grant_o[1])));
  a_r6_no_purge_committed: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o[1] && commit1_i) |=> !purge1_o);
  a_r9_refetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    refetch1_o |=> !refetch1_o);
  a_r9_refetch_after_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    refetch1_o |-> ($past(grant_o[0]) && !grant_o[0]));
  a_r11_stage1_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
    stage_ok_o[1] |-> req_act_i[1]);
endmodule

bind tx_prio_arb tx_prio_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_act_i  (req_act_i),
  .commit1_i  (commit1_i),
  .grant_o    (grant_o),
  .purge1_o   (purge1_o),
  .refetch1_o (refetch1_o),
  .stage_ok_o (stage_ok_o)
);

// File: tb/tx_prio_arb_tb_top.sv
module tx_prio_arb_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] req_act_i;
  logic [1:0] hold_i;
  logic       preempt_en_i;
  logic       stage1_en_i;
  logic       svc_opp_i;
  logic       commit1_i;
  logic [1:0] grant_o;
  logic       purge1_o;
  logic       refetch1_o;
  logic [1:0] stage_ok_o;

  int checks = 0;
  int errors = 0;

  tx_prio_arb dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in();
    req_act_i = 2'b00; hold_i = 2'b00; preempt_en_i = 1'b0;
    stage1_en_i = 1'b0; svc_opp_i = 1'b0; commit1_i = 1'b0;
  endtask

  task automatic go_idle();
    clear_in();
    step(); step(); step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) step();
    // R1 reset state
    chk(grant_o == 2'b00, "R1 grant", grant_o, 0);
    chk(!purge1_o && !refetch1_o, "R1 strobes", {purge1_o, refetch1_o}, 0);
    rst_n = 1'b1;
    step();
    chk(grant_o == 2'b00, "R1 grant after release", grant_o, 0);

    // R2: arbitration from idle, all request patterns
    for (int a = 0; a < 4; a++) begin
      logic [1:0] e;
      go_idle();
      req_act_i = a[1:0];
      step();
      e = a[0] ? 2'b01 : (a[1] ? 2'b10 : 2'b00);
      chk(grant_o == e, "R2 idle arbitration", grant_o, e);
    end

    // R4 R5 R6 R7 R9 R11 R12: every displacement input combination
    for (int k = 0; k < 32; k++) begin
      logic mv;
      go_idle();
      req_act_i = 2'b10;
      step();
      req_act_i    = {1'b1, k[0]};
      preempt_en_i = k[1];
      commit1_i    = k[2];
      hold_i       = {k[3], 1'b0};
      svc_opp_i    = k[4];
      step();
      mv = k[0] & k[1] & ~k[2] & ~(k[3] & k[4]);
      chk(grant_o == (mv ? 2'b01 : 2'b10), "R4/R5/R6/R7 grant", grant_o, mv ? 1 : 2);
      chk(purge1_o == mv, "R5 purge", purge1_o, mv);
      chk(!refetch1_o, "R9 no early refetch", refetch1_o, 0);
      if (mv) begin
        stage1_en_i = 1'b1;
        #1;
        chk(!stage_ok_o[1], "R11 blocked while preempted", stage_ok_o[1], 0);
        step();
        chk(!purge1_o, "R5 purge one cycle", purge1_o, 0);
        req_act_i = 2'b10; hold_i = 2'b00;
        step();
        chk(refetch1_o, "R9 refetch on release", refetch1_o, 1);
        chk(grant_o == 2'b10, "R12 handoff to ch1", grant_o, 2);
        chk(stage_ok_o[1], "R11 unblocked after refetch", stage_ok_o[1], 1);
        step();
        chk(!refetch1_o, "R9 refetch one cycle", refetch1_o, 0);
      end
    end

    // R6: committed frame delays the preemption to its boundary
    go_idle();
    req_act_i = 2'b10; step();
    req_act_i = 2'b11; preempt_en_i = 1'b1; commit1_i = 1'b1;
    step(); step();
    chk(grant_o == 2'b10 && !purge1_o, "R6 committed kept", {grant_o, purge1_o}, 4);
    commit1_i = 1'b0;
    step();
    chk(grant_o == 2'b01 && purge1_o, "R6 preempt at boundary", {grant_o, purge1_o}, 3);

    // R3: channel 0 keeps grant while active
    hold_i = 2'b10; svc_opp_i = 1'b1;
    step(); step();
    chk(grant_o == 2'b01, "R3 ch0 keeps", grant_o, 1);

    // R8: ch0 hold during service opportunity
    go_idle();
    req_act_i = 2'b01; step();
    req_act_i = 2'b10; hold_i = 2'b01; svc_opp_i = 1'b1;
    step(); step();
    chk(grant_o == 2'b01, "R8 ch0 held", grant_o, 1);
    svc_opp_i = 1'b0;
    step();
    chk(grant_o == 2'b10, "R12 release to ch1", grant_o, 2);
    chk(!refetch1_o, "R9 no refetch without preempt", refetch1_o, 0);

    // R7: ch1 hold keeps grant after its request drops
    req_act_i = 2'b00; hold_i = 2'b10; svc_opp_i = 1'b1;
    step();
    chk(grant_o == 2'b10, "R7 ch1 held", grant_o, 2);
    hold_i = 2'b00;
    step();
    chk(grant_o == 2'b00, "R12 release to idle", grant_o, 0);

    // R10 R11: staging gate sweep
    go_idle();
    for (int k = 0; k < 16; k++) begin
      logic [1:0] e;
      req_act_i = k[1:0]; stage1_en_i = k[2]; svc_opp_i = k[3];
      #1;
      e = {k[1] & (k[2] | k[3]), k[0]};
      chk(stage_ok_o == e, "R10/R11 staging", stage_ok_o, e);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule